// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to its working state. After a start pulse it keeps the memory deselected with the clock enable low for a settling pause derived from the clock frequency. It then raises the clock enable with a NOP and closes every bank with a precharge. Eight auto-refresh commands follow, then a load of the standard mode register and a load of the extended mode register. Programmable NOP gaps separate the commands so that the precharge, refresh-cycle and mode-load timings of the device are met.

Once the extended load has settled, the sequencer reports completion with a one-cycle flag and stays in normal mode, where it drives NOPs. It also starts a free-running refresh timer whose period is 15.625 us worth of clock cycles. The timer raises a refresh request that the memory controller acknowledges. All timing constants come from the `CLK_HZ` parameter at elaboration. Only the per-command gaps and the two mode words are inputs.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted (rstN low), the four command pins are all high, CKE is low, ba and addr are zero, and initDone and refreshReq are low.
- R2: From the clock edge that captures start, the command pins stay at deselect (all high) and CKE stays low for PAUSE_CYC = (CLK_HZ/1e6)*200 cycles. CKE rises together with the first NOP exactly PAUSE_CYC+1 edges after the capturing edge, and it never falls again.
- R3: Command encoding on {csN,rasN,casN,weN}: deselect 1111, NOP 0111, precharge 0010, auto-refresh 0001, mode-register load 0000.
- R4: The commands come in a fixed order: NOP, precharge with addr[10]=1 and all other address bits zero, eight auto-refreshes, standard mode load, extended mode load, and then only NOPs.
- R5: The first NOP is followed directly by the precharge. Each command is followed by tRp+1 NOP cycles after the precharge, tRfc+1 after each auto-refresh, and tMrd+1 after each mode load. ba and addr are zero on NOP and auto-refresh cycles.
- R6: The standard mode load drives ba=2'b00 with addr=modeWord. The extended mode load drives ba=2'b10 (bit 1 set, bit 0 clear) with addr=extModeWord.
- R7: initDone is high for exactly one cycle, on the cycle that directly follows the last NOP of the gap after the extended mode load.
- R8: start has no effect while a sequence is running or after initDone has been given; the command trace, CKE and all timing stay unchanged until the next reset.
- R9: refreshReq first rises REF_CYC = floor(CLK_HZ*15.625e-6) cycles after the edge on which initDone rises, and a new period expires every REF_CYC cycles after that, whatever the acknowledgements.
- R10: refreshReq stays high until refreshAck is sampled high, and falls on the edge that samples the acknowledge. It is never high before initDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the controller and of the SDRAM |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins the power-up sequence when the block is idle |
| tRp | input | DLY_W | Precharge gap, giving tRp+1 NOP cycles |
| tRfc | input | DLY_W | Gap after each auto-refresh, giving tRfc+1 NOP cycles |
| tMrd | input | DLY_W | Gap after each mode load, giving tMrd+1 NOP cycles |
| modeWord | input | ADDR_W | Address value for the standard mode load (CAS latency, burst length) |
| extModeWord | input | ADDR_W | Address value for the extended mode load (low-power settings) |
| refreshAck | input | 1 | Clears a pending refresh request |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | SDRAM address bus |
| initDone | output | 1 | One-cycle pulse when normal mode is reached |
| refreshReq | output | 1 | Pending periodic refresh request |

## Verification
The bench compares every cycle of the pins against a trace it builds itself from the programmed gaps. It uses zero gaps, maximum gaps and random gaps. A design that is off by one in a gap counter, or that stops after seven or nine refreshes, shifts every later command and fails. It also checks the pause length down to the exact edge, because an early CKE or a stray toggle during the settling time would break the device's power-up rule. Start pulses arrive during the pause, during a gap and after completion; a design that restarted would at once bring CKE low or repeat the recipe. The refresh request is held for many cycles without acknowledge, acknowledged once, and then timed to its next expiry. This catches a timer that restarts on acknowledge or drops the request on its own.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PRECH = 4'b0010,
    CMD_AREF  = 4'b0001,
    CMD_MODE  = 4'b0000
  } cmd_e;

  typedef enum logic [1:0] {
    GAP_PAUSE,
    GAP_TRP,
    GAP_TRFC,
    GAP_TMRD
  } gap_sel_e;

  typedef enum logic [1:0] {
    ADR_ZERO,
    ADR_ALLBANK,
    ADR_MODE,
    ADR_EXT
  } adr_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    cmd_e     cmd;
    adr_sel_e adrSel;
    logic     cntLoad;
    gap_sel_e cntSel;
    logic     cntDec;
    logic     arefClr;
    logic     arefInc;
    logic     ckeOn;
    logic     doneP;
    logic     armTimer;
  } strobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cntZero,
  input  logic    arefAll,
  output strobe_t stb
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PAUSE, ST_NOP, ST_PRECH, ST_PRE_GAP,
    ST_AREF, ST_AREF_GAP, ST_LMR, ST_LMR_GAP,
    ST_EMR, ST_EMR_GAP, ST_DONE, ST_RUN
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb        = '0;
    stb.cmd    = CMD_NOP;
    stb.adrSel = ADR_ZERO;
    stb.cntSel = GAP_PAUSE;
    nxt        = state;
    case (state)
      ST_IDLE: begin
        stb.cmd = CMD_DESEL;
        if (start) begin
          stb.cntLoad = 1'b1;
          stb.cntSel  = GAP_PAUSE;
          nxt         = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        stb.cmd = CMD_DESEL;
        if (cntZero) nxt = ST_NOP;
        else         stb.cntDec = 1'b1;
      end
      ST_NOP: begin
        stb.ckeOn = 1'b1;
        nxt       = ST_PRECH;
      end
      ST_PRECH: begin
        stb.cmd     = CMD_PRECH;
        stb.adrSel  = ADR_ALLBANK;
        stb.cntLoad = 1'b1;
        stb.cntSel  = GAP_TRP;
        stb.arefClr = 1'b1;
        nxt         = ST_PRE_GAP;
      end
      ST_PRE_GAP: begin
        if (cntZero) nxt = ST_AREF;
        else         stb.cntDec = 1'b1;
      end
      ST_AREF: begin
        stb.cmd     = CMD_AREF;
        stb.arefInc = 1'b1;
        stb.cntLoad = 1'b1;
        stb.cntSel  = GAP_TRFC;
        nxt         = ST_AREF_GAP;
      end
      ST_AREF_GAP: begin
        if (cntZero) nxt = arefAll ? ST_LMR : ST_AREF;
        else         stb.cntDec = 1'b1;
      end
      ST_LMR: begin
        stb.cmd     = CMD_MODE;
        stb.adrSel  = ADR_MODE;
        stb.cntLoad = 1'b1;
        stb.cntSel  = GAP_TMRD;
        nxt         = ST_LMR_GAP;
      end
      ST_LMR_GAP: begin
        if (cntZero) nxt = ST_EMR;
        else         stb.cntDec = 1'b1;
      end
      ST_EMR: begin
        stb.cmd     = CMD_MODE;
        stb.adrSel  = ADR_EXT;
        stb.cntLoad = 1'b1;
        stb.cntSel  = GAP_TMRD;
        nxt         = ST_EMR_GAP;
      end
      ST_EMR_GAP: begin
        if (cntZero) nxt = ST_DONE;
        else         stb.cntDec = 1'b1;
      end
      ST_DONE: begin
        stb.doneP    = 1'b1;
        stb.armTimer = 1'b1;
        nxt          = ST_RUN;
      end
      ST_RUN:  nxt = ST_RUN;
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sdram_init_dpath.sv
module sdram_init_dpath
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned REF_CYC   = 1562,
  parameter int unsigned NUM_AREF  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DLY_W-1:0]  tRp,
  input  logic [DLY_W-1:0]  tRfc,
  input  logic [DLY_W-1:0]  tMrd,
  input  logic [ADDR_W-1:0] modeWord,
  input  logic [ADDR_W-1:0] extModeWord,
  input  logic              refreshAck,
  output logic              cntZero,
  output logic              arefAll,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refreshReq
);

  localparam int unsigned PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int unsigned CNT_W   = (PAUSE_W > DLY_W) ? PAUSE_W : DLY_W;
  localparam int unsigned AREF_W  = $clog2(NUM_AREF + 1);
  localparam int unsigned TMR_W   = $clog2(REF_CYC + 1);
  localparam int unsigned AP_BIT  = 10;

  logic [CNT_W-1:0]  gapCnt, gapLoad;
  logic [AREF_W-1:0] arefCnt;
  logic [TMR_W-1:0]  tmrCnt;
  logic              tmrRun;
  logic [ADDR_W-1:0] addrNxt;

  // shared gap / pause counter
  always_comb begin
    case (stb.cntSel)
      GAP_PAUSE: gapLoad = CNT_W'(PAUSE_CYC - 1);
      GAP_TRP:   gapLoad = CNT_W'(tRp);
      GAP_TRFC:  gapLoad = CNT_W'(tRfc);
      default:   gapLoad = CNT_W'(tMrd);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gapCnt <= '0;
    else if (stb.cntLoad) gapCnt <= gapLoad;
    else if (stb.cntDec)  gapCnt <= gapCnt - CNT_W'(1);
  end

  assign cntZero = (gapCnt == '0);

  // auto-refresh tally
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            arefCnt <= '0;
    else if (stb.arefClr) arefCnt <= '0;
    else if (stb.arefInc) arefCnt <= arefCnt + AREF_W'(1);
  end

  assign arefAll = (arefCnt == AREF_W'(NUM_AREF));

  // registered pin drive
  always_comb begin
    case (stb.adrSel)
      ADR_ALLBANK: addrNxt = ADDR_W'(1) << AP_BIT;
      ADR_MODE:    addrNxt = modeWord;
      ADR_EXT:     addrNxt = extModeWord;
      default:     addrNxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= CMD_DESEL;
      cke      <= 1'b0;
      ba       <= 2'b00;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      {csN, rasN, casN, weN} <= stb.cmd;
      if (stb.ckeOn) cke <= 1'b1;
      ba       <= (stb.adrSel == ADR_EXT) ? 2'b10 : 2'b00;
      addr     <= addrNxt;
      initDone <= stb.doneP;
    end
  end

  // periodic refresh timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrRun     <= 1'b0;
      tmrCnt     <= '0;
      refreshReq <= 1'b0;
    end else begin
      if (stb.armTimer) begin
        tmrRun <= 1'b1;
        tmrCnt <= TMR_W'(REF_CYC - 1);
      end else if (tmrRun) begin
        if (tmrCnt == '0) tmrCnt <= TMR_W'(REF_CYC - 1);
        else              tmrCnt <= tmrCnt - TMR_W'(1);
      end
      if (tmrRun && tmrCnt == '0) refreshReq <= 1'b1;
      else if (refreshAck)        refreshReq <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DLY_W    = 4,
  parameter int unsigned NUM_AREF = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DLY_W-1:0]  tRp,
  input  logic [DLY_W-1:0]  tRfc,
  input  logic [DLY_W-1:0]  tMrd,
  input  logic [ADDR_W-1:0] modeWord,
  input  logic [ADDR_W-1:0] extModeWord,
  input  logic              refreshAck,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refreshReq
);

  // 200 us settling pause and 15.625 us refresh period, in clock cycles
  localparam int unsigned PAUSE_CYC = (CLK_HZ / 1_000_000) * 200;
  localparam int unsigned REF_CYC   =
    32'((64'(CLK_HZ) / 64'd1000 * 64'd15625) / 64'd1_000_000);

  strobe_t stb;
  logic    cntZero;
  logic    arefAll;

  sdram_init_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cntZero (cntZero),
    .arefAll (arefAll),
    .stb     (stb)
  );

  sdram_init_dpath #(
    .ADDR_W    (ADDR_W),
    .DLY_W     (DLY_W),
    .PAUSE_CYC (PAUSE_CYC),
    .REF_CYC   (REF_CYC),
    .NUM_AREF  (NUM_AREF)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .tRp         (tRp),
    .tRfc        (tRfc),
    .tMrd        (tMrd),
    .modeWord    (modeWord),
    .extModeWord (extModeWord),
    .refreshAck  (refreshAck),
    .cntZero     (cntZero),
    .arefAll     (arefAll),
    .cke         (cke),
    .csN         (csN),
    .rasN        (rasN),
    .casN        (casN),
    .weN         (weN),
    .ba          (ba),
    .addr        (addr),
    .initDone    (initDone),
    .refreshReq  (refreshReq)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              refreshAck,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              initDone,
  input logic              refreshReq
);

  logic [3:0] pins;
  logic       seenDone;

  assign pins = {csN, rasN, casN, weN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenDone <= 1'b0;
    else if (initDone) seenDone <= 1'b1;
  end

  AST_DESEL_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> pins == 4'b1111);  // R2

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);  // R2

  AST_PRECH_ALL_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    pins == 4'b0010 |-> addr[10]);  // R4

  AST_MODE_BANK_CODE: assert property (@(posedge clk) disable iff (!rstN)
    pins == 4'b0000 |-> (ba == 2'b00 || ba == 2'b10));  // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> !initDone);  // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && !refreshAck |=> refreshReq);  // R10

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !seenDone |-> !refreshReq);  // R10

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int P          = (CLK_HZ / 1_000_000) * 200;      // pause cycles
  localparam int R          = (CLK_HZ / 1000) * 15625 / 1_000_000; // refresh period
  localparam int NAREF      = 8;

  localparam logic [3:0] E_DESEL = 4'b1111;
  localparam logic [3:0] E_NOP   = 4'b0111;
  localparam logic [3:0] E_PRE   = 4'b0010;
  localparam logic [3:0] E_REF   = 4'b0001;
  localparam logic [3:0] E_MODE  = 4'b0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  tRp = '0, tRfc = '0, tMrd = '0;
  logic [12:0] modeWord = '0, extModeWord = '0;
  logic        refreshAck = 1'b0;
  logic        cke, csN, rasN, casN, weN, initDone, refreshReq;
  logic [1:0]  ba;
  logic [12:0] addr;

  int nChecks = 0;
  int nFail   = 0;
  bit ended   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_init_seq #(.CLK_HZ(CLK_HZ)) u_sdram_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .tRp(tRp), .tRfc(tRfc), .tMrd(tMrd),
    .modeWord(modeWord), .extModeWord(extModeWord), .refreshAck(refreshAck),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba),
    .addr(addr), .initDone(initDone), .refreshReq(refreshReq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {cmd[3:0], addrKind[1:0], done}; addrKind 0 zero, 1 all-bank, 2 mode, 3 ext
  function automatic logic [6:0] expAt(int n, int trp, int trfc, int tmrd);
    int k;
    if (n <= P) return {E_DESEL, 2'd0, 1'b0};
    k = n - P - 1;
    if (k == 0) return {E_NOP, 2'd0, 1'b0};
    k--;
    if (k == 0) return {E_PRE, 2'd1, 1'b0};
    k--;
    if (k <= trp) return {E_NOP, 2'd0, 1'b0};
    k -= trp + 1;
    for (int i = 0; i < NAREF; i++) begin
      if (k == 0) return {E_REF, 2'd0, 1'b0};
      k--;
      if (k <= trfc) return {E_NOP, 2'd0, 1'b0};
      k -= trfc + 1;
    end
    if (k == 0) return {E_MODE, 2'd2, 1'b0};
    k--;
    if (k <= tmrd) return {E_NOP, 2'd0, 1'b0};
    k -= tmrd + 1;
    if (k == 0) return {E_MODE, 2'd3, 1'b0};
    k--;
    if (k <= tmrd) return {E_NOP, 2'd0, 1'b0};
    k -= tmrd + 1;
    if (k == 0) return {E_NOP, 2'd0, 1'b1};
    return {E_NOP, 2'd0, 1'b0};
  endfunction

  function automatic int doneEdge(int trp, int trfc, int tmrd);
    return P + 1 + 2 + (trp + 1) + NAREF * (trfc + 2) + 2 * (tmrd + 2);
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    start = 1'b0;
    refreshAck = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk({csN, rasN, casN, weN} == E_DESEL, "R1 pins", {csN, rasN, casN, weN}, E_DESEL);
    chk(cke == 1'b0, "R1 cke", cke, 0);
    chk(ba == 2'b00 && addr == '0, "R1 ba/addr", {ba, addr}, 0);
    chk(initDone == 1'b0 && refreshReq == 1'b0, "R1 flags", {initDone, refreshReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runSeq(input int trp, input int trfc, input int tmrd,
                        input logic [12:0] mw, input logic [12:0] ew, input bit pokes);
    int nd, na, last;
    logic [6:0] e;
    logic [12:0] expAddr;
    logic [1:0]  expBa;
    bit expReq;
    string t;
    tRp = 4'(trp); tRfc = 4'(trfc); tMrd = 4'(tmrd);
    modeWord = mw; extModeWord = ew;
    doReset();
    start = 1'b1;
    @(posedge clk);          // capturing edge 0
    @(negedge clk);
    start = 1'b0;
    nd   = doneEdge(trp, trfc, tmrd);
    na   = nd + R + 20;
    last = nd + 2 * R + 3;
    for (int n = 1; n <= last; n++) begin
      @(posedge clk);
      @(negedge clk);
      e = expAt(n, trp, trfc, tmrd);
      case (e[2:1])
        2'd1:    expAddr = 13'h400;
        2'd2:    expAddr = mw;
        2'd3:    expAddr = ew;
        default: expAddr = '0;
      endcase
      expBa  = (e[2:1] == 2'd3) ? 2'b10 : 2'b00;
      expReq = (n >= nd + R && n < na) || (n >= nd + 2 * R);
      t = (n <= P) ? "R2 pause cmd" : (pokes ? "R3 R4 R5 R8 cmd" : "R3 R4 R5 cmd");
      chk({csN, rasN, casN, weN} == e[6:3], t, {csN, rasN, casN, weN}, e[6:3]);
      chk(cke == (n > P), "R2 cke", cke, (n > P));
      chk(addr == expAddr, "R4 R6 addr", addr, expAddr);
      chk(ba == expBa, "R6 ba", ba, expBa);
      chk(initDone == e[0], "R7 initDone", initDone, e[0]);
      chk(refreshReq == expReq, "R9 R10 refreshReq", refreshReq, expReq);
      // drive for next edge
      refreshAck = (n == na - 1);
      start = pokes && (n == 100 || n == P + 4 || n == nd + 5);
    end
    refreshAck = 1'b0;
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed corners: shortest and longest gaps, start pokes on both
    runSeq(0, 0, 0, 13'h0033, 13'h0000, 1'b1);
    runSeq(15, 15, 15, 13'h1FFF, 13'h1FFF, 1'b1);
    // constrained random gaps and mode words
    for (int i = 0; i < 4; i++) begin
      runSeq(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
             int'($urandom_range(0, 15)), 13'($urandom), 13'($urandom), (i % 2) == 0);
    end
    ended = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule